// File: doc/BRIEF.md
# Receive Endpoint Buffer with Banked Storage

This block holds the data of host-to-device packets for one endpoint of a USB device controller. It has one or two banks of byte storage. The bus side writes a packet into the free bank its write pointer selects. When the packet ends well, the bank becomes owned by the CPU. The bus side gets an ACK, or a NAK when no bank was free at the packet's start. The CPU side sees a receive-done flag and a bank-busy flag for the bank it currently points at. It reads the byte count, pulls bytes one per read strobe, and hands the bank back. Handing it back moves the CPU pointer to the other bank.

The receive-done flag and the bank-busy flag are separate. Acknowledging the interrupt clears only the receive-done flag; only a release frees storage. With two banks the bus side fills the second bank while the CPU drains the first. When the first is released and the second is already full, the receive-done flag is raised again at once. For isochronous use, a host IN request that finds the bus-side bank empty sets an underflow flag and triggers a zero-length packet. Each of the two flags has its own interrupt enable.

Top module: `rxep_out_buffer`

## Requirements
- R1: After reset, rx_flag, bank_busy, undr_flag, irq, hs_valid, zlp_send and rd_allowed are 0, and byte_count is 0.
- R2: When a packet ends with pk_end_ok, then on the next cycle hs_valid=1 with hs_ack=1, the written bank is full, and byte_count equals the number of bytes written. If that bank is the CPU's current bank, rx_flag=1 and bank_busy=1 on that cycle.
- R3: irq is 1 exactly when (rx_flag and rx_ie) or (undr_flag and undr_ie).
- R4: A pulse on ack_rx clears rx_flag on the next cycle. bank_busy and byte_count are unchanged.
- R5: While rd_allowed=1, rd_data shows the bytes of the current bank in write order. Each rd_strobe advances to the next byte and lowers byte_count by one. rd_allowed is 1 only while bank_busy=1 and byte_count is not 0.
- R6: A rd_strobe while rd_allowed=0 leaves byte_count and the flags unchanged, and rd_data reads 0.
- R7: A release_bank pulse while bank_busy=1 frees the current bank, clears rx_flag, and moves the CPU pointer to the next bank (mod NUM_BANKS). With one bank, bank_busy, rx_flag and byte_count are 0 on the next cycle. A release while bank_busy=0 is ignored.
- R8: With two banks, a packet completes into the non-current bank without setting rx_flag. When the current bank is released, rx_flag=1 and bank_busy=1 on the next cycle, and byte_count is the stored packet's length.
- R9: If the bank under the bus write pointer is full at pk_start, the packet's bytes are discarded. At its end, hs_valid=1 with hs_ack=0, and the stored banks are unchanged.
- R10: A packet that ends with pk_end_bad produces no handshake and leaves its bank free and unflagged. The next packet is written from byte 0.
- R11: With iso_mode=1, an iso_in_req while the bank under the bus write pointer is not full sets undr_flag. zlp_send is then 1 for exactly one cycle. With iso_mode=0, or with that bank full, the request does nothing. undr_ack clears undr_flag.
- R12: Each bank holds BANK_DEPTH (64) bytes. Bytes beyond that in one packet are dropped, and byte_count saturates at 64 (the count is 7 bits wide).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_start | input | 1 | Start of an OUT packet |
| pk_byte_valid | input | 1 | pk_byte carries a data byte |
| pk_byte | input | 8 | Packet data byte |
| pk_end_ok | input | 1 | Packet ended with good status |
| pk_end_bad | input | 1 | Packet ended with bad status |
| hs_valid | output | 1 | Handshake result is valid (one cycle) |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| iso_mode | input | 1 | Endpoint is isochronous |
| iso_in_req | input | 1 | Host IN read request |
| zlp_send | output | 1 | Send zero-length packet (one cycle) |
| rd_strobe | input | 1 | CPU reads one byte |
| rd_data | output | 8 | Byte at the CPU read position |
| byte_count | output | 7 | Unread bytes in the current bank |
| rd_allowed | output | 1 | Current bank holds unread data |
| rx_flag | output | 1 | Receive-done flag |
| rx_ie | input | 1 | Receive-done interrupt enable |
| ack_rx | input | 1 | Clear the receive-done flag |
| bank_busy | output | 1 | Current bank is owned by the CPU |
| release_bank | input | 1 | Free current bank and advance |
| undr_flag | output | 1 | Isochronous underflow flag |
| undr_ie | input | 1 | Underflow interrupt enable |
| undr_ack | input | 1 | Clear the underflow flag |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench runs a two-bank and a one-bank instance side by side on the same stimulus. The same second packet is therefore ACKed by one and NAKed by the other, and the same release re-raises the flag on one and empties the other. A design that tied release to the interrupt acknowledge, or that forgot to re-raise on release, shows up as a wrong rx_flag or bank_busy straight after the release. The bench also sweeps packet lengths from 0 to 8 with full read-back. It sends a 70-byte packet to catch a wrapped write pointer or a count that does not saturate. It follows a bad-status packet with a good one, so a write pointer that was not reset shows up as shifted data. Underflow is probed with the bus bank empty and full, so a design that ignores bank state answers the full case with a spurious zero-length packet.

// File: rtl/rxep_pkg.sv
package rxep_pkg;

  localparam int unsigned MAX_BANKS = 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FILL = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  function automatic logic next_bank(input logic cur, input int unsigned nb);
    if (nb > 1) return ~cur;
    return 1'b0;
  endfunction

  function automatic logic [7:0] drain_step(input logic [7:0] cnt);
    if (cnt == 8'd0) return 8'd0;
    return cnt - 8'd1;
  endfunction

endpackage

// File: rtl/rxep_bank.sv
module rxep_bank #(
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned CNT_W      = $clog2(BANK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic             rd_adv,
  input  logic             free_bank,
  output logic             full,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       head_byte
);
  import rxep_pkg::*;

  localparam int unsigned AW = $clog2(BANK_DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BANK_DEPTH);

  logic [7:0]       mem [BANK_DEPTH];
  logic [CNT_W-1:0] wptr, rptr, cnt_q;
  logic             full_q;
  logic             room;

  assign room = (wptr < DEPTH_C);

  always_ff @(posedge clk) begin
    if (wr_en && !full_q && room) mem[wptr[AW-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      wptr   <= '0;
      rptr   <= '0;
    end else if (free_bank) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      wptr   <= '0;
      rptr   <= '0;
    end else begin
      if (clr_wr && !full_q) wptr <= '0;
      else if (wr_en && !full_q && room) wptr <= wptr + CNT_W'(1);
      if (commit && !full_q) begin
        full_q <= 1'b1;
        cnt_q  <= wptr;
        wptr   <= '0;
        rptr   <= '0;
      end
      if (rd_adv && full_q && cnt_q != '0) begin
        cnt_q <= CNT_W'(drain_step(8'(cnt_q)));
        rptr  <= rptr + CNT_W'(1);
      end
    end
  end

  assign full      = full_q;
  assign count     = cnt_q;
  assign head_byte = mem[rptr[AW-1:0]];

endmodule

// File: rtl/rxep_bus_side.sv
module rxep_bus_side #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pk_start,
  input  logic       pk_byte_valid,
  input  logic       pk_end_ok,
  input  logic       pk_end_bad,
  input  logic [1:0] full_vec,
  output logic       wsel,
  output logic       clr_go,
  output logic       wr_go,
  output logic       commit_go,
  output logic       bad_end,
  output logic       hs_valid,
  output logic       hs_ack
);
  import rxep_pkg::*;

  rx_state_e st;
  logic      nak_end;
  logic      target_full;

  assign target_full = full_vec[wsel];
  assign clr_go      = pk_start && !target_full;
  assign wr_go       = (st == RX_FILL) && pk_byte_valid && !pk_start;
  assign commit_go   = (st == RX_FILL) && pk_end_ok && !pk_start;
  assign bad_end     = (st == RX_FILL) && pk_end_bad && !pk_start;
  assign nak_end     = (st == RX_DROP) && (pk_end_ok || pk_end_bad) && !pk_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      wsel     <= 1'b0;
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
    end else begin
      hs_valid <= commit_go || nak_end;
      hs_ack   <= commit_go;
      if (pk_start) begin
        st <= target_full ? RX_DROP : RX_FILL;
      end else if (commit_go || bad_end || nak_end) begin
        st <= RX_IDLE;
      end
      if (commit_go) wsel <= next_bank(wsel, NUM_BANKS);
    end
  end

endmodule

// File: rtl/rxep_cpu_side.sv
module rxep_cpu_side #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] full_vec,
  input  logic       commit_go,
  input  logic       wsel,
  input  logic       release_bank,
  input  logic       ack_rx,
  input  logic       iso_mode,
  input  logic       iso_in_req,
  input  logic       undr_ack,
  input  logic       rx_ie,
  input  logic       undr_ie,
  output logic       csel,
  output logic       free_go,
  output logic       raise_go,
  output logic       rx_flag,
  output logic       undr_flag,
  output logic       zlp_send,
  output logic       irq
);
  import rxep_pkg::*;

  logic csel_nxt;
  logic iso_hit;
  logic chained;

  assign free_go  = release_bank && full_vec[csel];
  assign csel_nxt = free_go ? next_bank(csel, NUM_BANKS) : csel;
  assign chained  = free_go && (NUM_BANKS > 1) && full_vec[csel_nxt];
  assign raise_go = (commit_go && (wsel == csel_nxt)) || chained;
  assign iso_hit  = iso_mode && iso_in_req && !full_vec[wsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csel      <= 1'b0;
      rx_flag   <= 1'b0;
      undr_flag <= 1'b0;
      zlp_send  <= 1'b0;
    end else begin
      csel <= csel_nxt;
      if (raise_go) rx_flag <= 1'b1;
      else if (ack_rx || free_go) rx_flag <= 1'b0;
      if (iso_hit) undr_flag <= 1'b1;
      else if (undr_ack) undr_flag <= 1'b0;
      zlp_send <= iso_hit;
    end
  end

  assign irq = (rx_flag && rx_ie) || (undr_flag && undr_ie);

endmodule

// File: rtl/rxep_out_buffer.sv
module rxep_out_buffer #(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned CNT_W      = $clog2(BANK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pk_start,
  input  logic             pk_byte_valid,
  input  logic [7:0]       pk_byte,
  input  logic             pk_end_ok,
  input  logic             pk_end_bad,
  output logic             hs_valid,
  output logic             hs_ack,
  input  logic             iso_mode,
  input  logic             iso_in_req,
  output logic             zlp_send,
  input  logic             rd_strobe,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] byte_count,
  output logic             rd_allowed,
  output logic             rx_flag,
  input  logic             rx_ie,
  input  logic             ack_rx,
  output logic             bank_busy,
  input  logic             release_bank,
  output logic             undr_flag,
  input  logic             undr_ie,
  input  logic             undr_ack,
  output logic             irq
);
  import rxep_pkg::*;

  logic [1:0]       full_vec;
  logic [CNT_W-1:0] cnt_arr  [MAX_BANKS];
  logic [7:0]       head_arr [MAX_BANKS];

  logic wsel, csel;
  logic clr_go, wr_go;
  logic ev_commit, ev_bad_end, ev_raise, ev_free;

  rxep_bus_side #(.NUM_BANKS(NUM_BANKS)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .pk_start(pk_start), .pk_byte_valid(pk_byte_valid),
    .pk_end_ok(pk_end_ok), .pk_end_bad(pk_end_bad),
    .full_vec(full_vec), .wsel(wsel),
    .clr_go(clr_go), .wr_go(wr_go), .commit_go(ev_commit),
    .bad_end(ev_bad_end), .hs_valid(hs_valid), .hs_ack(hs_ack)
  );

  rxep_cpu_side #(.NUM_BANKS(NUM_BANKS)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .full_vec(full_vec), .commit_go(ev_commit), .wsel(wsel),
    .release_bank(release_bank), .ack_rx(ack_rx),
    .iso_mode(iso_mode), .iso_in_req(iso_in_req), .undr_ack(undr_ack),
    .rx_ie(rx_ie), .undr_ie(undr_ie),
    .csel(csel), .free_go(ev_free), .raise_go(ev_raise),
    .rx_flag(rx_flag), .undr_flag(undr_flag), .zlp_send(zlp_send), .irq(irq)
  );

  for (genvar g = 0; g < MAX_BANKS; g++) begin : g_bank
    if (g < NUM_BANKS) begin : g_live
      logic b_full;
      rxep_bank #(.BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr_wr(clr_go && (wsel == 1'(g))),
        .wr_en(wr_go && (wsel == 1'(g))),
        .wr_byte(pk_byte),
        .commit(ev_commit && (wsel == 1'(g))),
        .rd_adv(rd_strobe && rd_allowed && (csel == 1'(g))),
        .free_bank(ev_free && (csel == 1'(g))),
        .full(b_full),
        .count(cnt_arr[g]),
        .head_byte(head_arr[g])
      );
      assign full_vec[g] = b_full;
    end else begin : g_absent
      assign full_vec[g] = 1'b0;
      assign cnt_arr[g]  = '0;
      assign head_arr[g] = 8'h00;
    end
  end

  assign bank_busy  = full_vec[csel];
  assign byte_count = cnt_arr[csel];
  assign rd_allowed = bank_busy && (byte_count != '0);
  assign rd_data    = rd_allowed ? head_arr[csel] : 8'h00;

endmodule

// File: rtl/rxep_checks.sv
module rxep_checks #(
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned CNT_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_rx,
  input logic             release_bank,
  input logic             rd_strobe,
  input logic             rd_allowed,
  input logic [CNT_W-1:0] byte_count,
  input logic             rx_flag,
  input logic             bank_busy,
  input logic             hs_valid,
  input logic             hs_ack,
  input logic             zlp_send,
  input logic             undr_flag,
  input logic             ev_commit,
  input logic             ev_bad_end,
  input logic             ev_raise
);

  // R2
  a_r2_commit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (hs_valid && hs_ack));

  // R4
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx && !ev_raise) |=> !rx_flag);

  // R4
  a_r4_ack_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx && bank_busy && !release_bank) |=> bank_busy);

  // R5
  a_r5_read_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_allowed && !release_bank) |=>
      ((byte_count + CNT_W'(1)) == $past(byte_count)));

  // R6
  a_r6_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_allowed && !release_bank && !ev_commit) |=> $stable(byte_count));

  // R10
  a_r10_bad_end_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_end |=> !hs_valid);

  // R11
  a_r11_zlp_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_send |-> undr_flag);

  // R12
  a_r12_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CNT_W'(BANK_DEPTH));

endmodule

bind rxep_out_buffer rxep_checks #(.BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .ack_rx(ack_rx), .release_bank(release_bank),
  .rd_strobe(rd_strobe), .rd_allowed(rd_allowed), .byte_count(byte_count),
  .rx_flag(rx_flag), .bank_busy(bank_busy), .hs_valid(hs_valid), .hs_ack(hs_ack),
  .zlp_send(zlp_send), .undr_flag(undr_flag), .ev_commit(ev_commit),
  .ev_bad_end(ev_bad_end), .ev_raise(ev_raise)
);

// File: tb/rxep_out_buffer_test.sv
`timescale 1ns/1ps
module rxep_out_buffer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic pk_start = 0, pk_byte_valid = 0, pk_end_ok = 0, pk_end_bad = 0;
  logic [7:0] pk_byte = 0;
  logic iso_mode = 0, iso_in_req = 0, rd_strobe = 0, rx_ie = 0, ack_rx = 0;
  logic release_bank = 0, undr_ie = 0, undr_ack = 0;

  logic hs_valid, hs_ack, zlp_send, rd_allowed, rx_flag, bank_busy, undr_flag, irq;
  logic [7:0] rd_data;
  logic [6:0] byte_count;
  logic hs_valid1, hs_ack1, zlp_send1, rd_allowed1, rx_flag1, bank_busy1, undr_flag1, irq1;
  logic [7:0] rd_data1;
  logic [6:0] byte_count1;

  rxep_out_buffer uut (
    .clk(clk), .rst_n(rst_n), .pk_start(pk_start), .pk_byte_valid(pk_byte_valid),
    .pk_byte(pk_byte), .pk_end_ok(pk_end_ok), .pk_end_bad(pk_end_bad),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .iso_mode(iso_mode), .iso_in_req(iso_in_req),
    .zlp_send(zlp_send), .rd_strobe(rd_strobe), .rd_data(rd_data), .byte_count(byte_count),
    .rd_allowed(rd_allowed), .rx_flag(rx_flag), .rx_ie(rx_ie), .ack_rx(ack_rx),
    .bank_busy(bank_busy), .release_bank(release_bank), .undr_flag(undr_flag),
    .undr_ie(undr_ie), .undr_ack(undr_ack), .irq(irq));

  rxep_out_buffer #(.NUM_BANKS(1)) uut_one (
    .clk(clk), .rst_n(rst_n), .pk_start(pk_start), .pk_byte_valid(pk_byte_valid),
    .pk_byte(pk_byte), .pk_end_ok(pk_end_ok), .pk_end_bad(pk_end_bad),
    .hs_valid(hs_valid1), .hs_ack(hs_ack1), .iso_mode(iso_mode), .iso_in_req(iso_in_req),
    .zlp_send(zlp_send1), .rd_strobe(rd_strobe), .rd_data(rd_data1), .byte_count(byte_count1),
    .rd_allowed(rd_allowed1), .rx_flag(rx_flag1), .rx_ie(rx_ie), .ack_rx(ack_rx),
    .bank_busy(bank_busy1), .release_bank(release_bank), .undr_flag(undr_flag1),
    .undr_ie(undr_ie), .undr_ack(undr_ack), .irq(irq1));

  int tests = 0;
  int fails = 0;
  logic hv, ha, hv1, ha1;
  logic [7:0] got, got1;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 3) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input int seed, input bit good);
    @(negedge clk) pk_start = 1;
    @(negedge clk) pk_start = 0;
    for (int i = 0; i < len; i++) begin
      pk_byte_valid = 1; pk_byte = pat(seed, i);
      @(negedge clk);
    end
    pk_byte_valid = 0;
    pk_end_ok = good; pk_end_bad = !good;
    @(negedge clk);
    pk_end_ok = 0; pk_end_bad = 0;
    #1;
    hv = hs_valid; ha = hs_ack; hv1 = hs_valid1; ha1 = hs_ack1;
  endtask

  task automatic read_byte();
    @(negedge clk);
    #1;
    got = rd_data; got1 = rd_data1;
    rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack_rx = 1;
    @(negedge clk) ack_rx = 0;
    #1;
  endtask

  task automatic pulse_rel();
    @(negedge clk) release_bank = 1;
    @(negedge clk) release_bank = 0;
    #1;
  endtask

  task automatic pulse_iso();
    @(negedge clk) iso_in_req = 1;
    @(negedge clk) iso_in_req = 0;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 rx_flag", rx_flag, 0);
    chk("R1 bank_busy", bank_busy, 0);
    chk("R1 byte_count", byte_count, 0);
    chk("R1 rd_allowed", rd_allowed, 0);
    chk("R1 undr_flag", undr_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 zlp_send", zlp_send, 0);

    // R2 first packet
    send_pkt(5, 1, 1);
    chk("R2 hs_valid", hv, 1);
    chk("R2 hs_ack", ha, 1);
    chk("R2 rx_flag", rx_flag, 1);
    chk("R2 bank_busy", bank_busy, 1);
    chk("R2 byte_count", byte_count, 5);
    chk("R2 one-bank count", byte_count1, 5);

    // R3 interrupt gating
    chk("R3 irq disabled", irq, 0);
    @(negedge clk) rx_ie = 1;
    #1 chk("R3 irq enabled", irq, 1);

    // R4 acknowledge keeps bank
    pulse_ack();
    chk("R4 rx_flag cleared", rx_flag, 0);
    chk("R4 bank_busy kept", bank_busy, 1);
    chk("R4 count kept", byte_count, 5);
    chk("R3 irq after ack", irq, 0);

    // R8 second bank fills; R9 one-bank NAK
    send_pkt(3, 2, 1);
    chk("R8 second bank ack", ha, 1);
    chk("R8 rx_flag not raised", rx_flag, 0);
    chk("R8 current count kept", byte_count, 5);
    chk("R9 one-bank hs_valid", hv1, 1);
    chk("R9 one-bank nak", ha1, 0);
    chk("R9 one-bank count kept", byte_count1, 5);

    // R5 partial read
    for (int i = 0; i < 2; i++) begin
      read_byte();
      chk("R5 byte", got, pat(1, i));
      chk("R5 one-bank byte", got1, pat(1, i));
    end
    chk("R5 count after 2", byte_count, 3);

    // R9 both banks full on two-bank instance
    send_pkt(2, 3, 1);
    chk("R9 hs_valid", hv, 1);
    chk("R9 nak", ha, 0);
    chk("R9 count unchanged", byte_count, 3);

    // R8 release re-raises; R7 one-bank empties
    pulse_rel();
    chk("R8 rx_flag re-raised", rx_flag, 1);
    chk("R8 bank_busy", bank_busy, 1);
    chk("R8 count of second", byte_count, 3);
    chk("R7 one-bank busy", bank_busy1, 0);
    chk("R7 one-bank rx_flag", rx_flag1, 0);
    chk("R7 one-bank count", byte_count1, 0);

    // R5 drain second bank (data must be packet B, not discarded C)
    for (int i = 0; i < 3; i++) begin
      read_byte();
      chk("R5 second bank byte", got, pat(2, i));
      chk("R6 one-bank empty read", got1, 0);
    end
    chk("R5 rd_allowed cleared", rd_allowed, 0);
    chk("R5 busy after drain", bank_busy, 1);

    // R6 read while not allowed
    read_byte();
    chk("R6 rd_data zero", got, 0);
    chk("R6 count stays", byte_count, 0);
    chk("R6 busy stays", bank_busy, 1);
    chk("R6 rx_flag stays", rx_flag, 1);

    // R7 release with other bank free
    pulse_rel();
    chk("R7 busy after release", bank_busy, 0);
    chk("R7 rx_flag after release", rx_flag, 0);
    pulse_rel();
    chk("R7 ignored release", bank_busy, 0);

    // R10 bad packet then good one
    send_pkt(4, 4, 0);
    chk("R10 no handshake", hv, 0);
    chk("R10 no handshake one-bank", hv1, 0);
    chk("R10 bank free", bank_busy, 0);
    chk("R10 no flag", rx_flag, 0);
    send_pkt(2, 5, 1);
    chk("R10 good after bad count", byte_count, 2);
    read_byte();
    chk("R10 first byte", got, pat(5, 0));
    chk("R10 first byte one-bank", got1, pat(5, 0));
    pulse_rel();

    // R12 overflow
    send_pkt(70, 6, 1);
    chk("R12 count saturates", byte_count, 64);
    chk("R12 one-bank count", byte_count1, 64);
    for (int i = 0; i < 64; i++) begin
      read_byte();
      chk("R12 stored byte", got, pat(6, i));
    end
    chk("R12 drained", rd_allowed, 0);
    pulse_rel();

    // R5 length sweep incl. zero-length
    for (int len = 0; len <= 8; len++) begin
      send_pkt(len, 10 + len, 1);
      chk("R2 sweep ack", ha, 1);
      chk("R2 sweep rx_flag", rx_flag, 1);
      chk("R5 sweep count", byte_count, len);
      chk("R5 sweep rd_allowed", rd_allowed, (len != 0) ? 1 : 0);
      for (int i = 0; i < len; i++) begin
        read_byte();
        chk("R5 sweep byte", got, pat(10 + len, i));
        chk("R5 sweep byte one-bank", got1, pat(10 + len, i));
        chk("R5 sweep decrement", byte_count, len - 1 - i);
      end
      pulse_ack();
      pulse_rel();
      chk("R7 sweep released", bank_busy, 0);
    end

    // R11 underflow
    pulse_iso();
    chk("R11 no iso mode", undr_flag, 0);
    chk("R11 no iso zlp", zlp_send, 0);
    @(negedge clk) iso_mode = 1; undr_ie = 1;
    pulse_iso();
    chk("R11 zlp pulse", zlp_send, 1);
    chk("R11 undr_flag", undr_flag, 1);
    chk("R3 irq from underflow", irq, 1);
    @(negedge clk) #1;
    chk("R11 zlp one cycle", zlp_send, 0);
    @(negedge clk) undr_ack = 1;
    @(negedge clk) undr_ack = 0;
    #1 chk("R11 undr_ack clears", undr_flag, 0);
    send_pkt(1, 30, 1);
    pulse_iso();
    chk("R11 one-bank full no zlp", zlp_send1, 0);
    chk("R11 one-bank full no flag", undr_flag1, 0);
    chk("R11 two-bank empty zlp", zlp_send, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule